// File: doc/BRIEF.md
# Display Processor Host Command Port

This block is the host-facing command front end of a tile-based video display processor. The host reaches it through two ports: a data port and a control port. Each port takes 16-bit or 32-bit accesses. A single control word either writes one entry of a 32-entry byte register file, or opens a two-word command that loads the current access address and a 6-bit access code. Each data-port access becomes one strobe towards the video memories. The strobe carries the even-aligned current address and the low four code bits, which select the target memory. The address then advances by the programmed increment.

When the second command word completes with transfers enabled, the block sends a one-cycle request to an external transfer engine. The request carries the operation, source, destination, length, increment and filler. A memory-to-video-memory transfer starts at once. A fill is only armed by the command, and the next data-port write fires it and supplies the filler word. A copy starts at once. The block also assembles the 16-bit status word from flag inputs. The memories, the transfer engine and the renderer sit outside the block.

Top module: `dpc_host_port`

## Requirements
- R1: After reset the register file, the address, the access code, the pending-second-word flag and the fill-armed flag are all zero, `bus_ready` is 1 and no strobe is raised; a first data access then targets address 0 with code 0.
- R2: A control word with bits 15:13 = 3'b100, accepted while no second word is pending, writes bits 7:0 into register bits 12:8. Register 15 is the increment, registers 20:19 the 16-bit length (high:low), registers 23:21 the source (high, mid, low), and register 1 bit 4 the transfer enable.
- R3: Any other control word accepted while no second word is pending loads code bits 1:0 from bits 15:14 and address bits 13:0 from bits 13:0. It clears address bits 15:14 and code bits 5:2 and sets the pending flag.
- R4: While the pending flag is set, the next control word is always the second word, even if bits 15:13 = 3'b100. Its bits 1:0 become address bits 15:14 and its bits 7:4 become code bits 5:2. The pending flag clears and no register is written.
- R5: A data access accepted at a clock edge gives `mem_stb` high for the following cycle. That cycle carries `mem_addr` = current address with bit 0 forced to 0, `mem_we` = the access direction, `mem_wdata` = the word, and `mem_tgt` = code bits 3:0. The address then grows by the 8-bit increment, modulo 2^16.
- R6: A 32-bit access (`bus_wide`) is split into its upper half and then its lower half, handled on two consecutive edges. `bus_ready` is low for the one cycle between them, and requests in that cycle are ignored. Data halves each apply the increment. Control halves act as two control words.
- R7: A transfer request comes only from a second word that leaves code bits 5:4 nonzero while register 1 bit 4 is set. Otherwise only the address and code update.
- R8: If register 23 bits 7:6 are 0 or 1, `dma_op` = 0 and `dma_src` = {reg23[6:0], reg22, reg21, 0}. `dma_len` = (length × increment) mod 2^16 bytes, and the address then advances by `dma_len`. For every request, `dma_dst` is the address when the request fires, `dma_inc` is register 15 and `dma_tgt` is code bits 3:0.
- R9: If register 23 bits 7:6 = 2, no request fires and fill is armed. The next data-port write raises no `mem_stb`. It instead pulses `dma_op` = 1 with `dma_fill` = the written word, `dma_len` = length and the current address, leaves the address unchanged and disarms. Reads while armed behave normally.
- R10: If register 23 bits 7:6 = 3, a request with `dma_op` = 2 and `dma_len` = length fires at once, and the address stays at the decoded value.
- R11: `status_word` bit 9 = FIFO empty, 8 = FIFO full, 7 = vertical interrupt, 6 = sprite overflow, 5 = sprite collision, 4 = odd frame, 3 = vertical blank, 2 = horizontal blank, 1 = transfer busy, 0 = PAL; bits 15:10 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request, one cycle |
| bus_ctrl | input | 1 | 1 = control port, 0 = data port |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access |
| bus_wdata | input | 32 | Write word; narrow accesses use bits 15:0 |
| bus_ready | output | 1 | Low while the lower half of a wide access is handled |
| fifo_empty | input | 1 | Status flag, bit 9 |
| fifo_full | input | 1 | Status flag, bit 8 |
| vint_flag | input | 1 | Status flag, bit 7 |
| spr_ovf | input | 1 | Status flag, bit 6 |
| spr_hit | input | 1 | Status flag, bit 5 |
| odd_field | input | 1 | Status flag, bit 4 |
| in_vblank | input | 1 | Status flag, bit 3 |
| in_hblank | input | 1 | Status flag, bit 2 |
| xfer_busy | input | 1 | Status flag, bit 1 |
| pal_std | input | 1 | Status flag, bit 0 |
| status_word | output | 16 | Assembled status word |
| mem_stb | output | 1 | Video memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Even byte address |
| mem_wdata | output | 16 | Data word |
| mem_tgt | output | 4 | Code bits 3:0 |
| dma_stb | output | 1 | Transfer request pulse |
| dma_op | output | 2 | 0 memory-to-video, 1 fill, 2 copy |
| dma_src | output | 24 | Source byte address |
| dma_dst | output | 16 | Destination address |
| dma_len | output | 16 | Length |
| dma_inc | output | 8 | Increment |
| dma_fill | output | 16 | Filler word (fill only, else 0) |
| dma_tgt | output | 4 | Code bits 3:0 |

## Verification
A wrong address, code or flag is visible at the ports on the next data access or second command word. A bad address shows as a wrong `mem_addr`. A bad code shows as a wrong `mem_tgt`, or as a transfer that fires or fails to fire. A stuck pending or armed flag shows as a register write that is lost, or as a data write that turns into a fill or stays a store. Because the bench compares every strobe and every field against an independent model each cycle, any such divergence is reported on the first strobe that exposes it. That is usually one or two accesses after the fault.

// File: rtl/dpc_host_port.sv
module dpc_host_port #(
  parameter int NREGS = 32,
  parameter int RIDX_W = $clog2(NREGS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_ctrl,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [31:0] bus_wdata,
  output logic        bus_ready,
  input  logic        fifo_empty,
  input  logic        fifo_full,
  input  logic        vint_flag,
  input  logic        spr_ovf,
  input  logic        spr_hit,
  input  logic        odd_field,
  input  logic        in_vblank,
  input  logic        in_hblank,
  input  logic        xfer_busy,
  input  logic        pal_std,
  output logic [15:0] status_word,
  output logic        mem_stb,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [3:0]  mem_tgt,
  output logic        dma_stb,
  output logic [1:0]  dma_op,
  output logic [23:0] dma_src,
  output logic [15:0] dma_dst,
  output logic [15:0] dma_len,
  output logic [7:0]  dma_inc,
  output logic [15:0] dma_fill,
  output logic [3:0]  dma_tgt
);
  localparam int RMODE = 1;
  localparam int RINC  = 15;
  localparam int RLENL = 19;
  localparam int RLENH = 20;
  localparam int RSRCL = 21;
  localparam int RSRCM = 22;
  localparam int RSRCH = 23;
  localparam logic [1:0] OP_MEM  = 2'd0;
  localparam logic [1:0] OP_FILL = 2'd1;
  localparam logic [1:0] OP_COPY = 2'd2;

  logic [7:0]  regs [NREGS];
  logic [15:0] addr;
  logic [5:0]  code;
  logic        pend, armed;
  logic        half_pend, half_ctrl, half_wr;
  logic [15:0] half_word;

  logic        act, a_ctrl, a_wr;
  logic [15:0] a_word;
  logic        is_reg, is_first, is_second, is_data, fill_go, dma_go, dma_en;
  logic [15:0] addr2, len, byte_cnt;
  logic [5:0]  code2;
  logic [7:0]  inc;
  logic [23:0] src;
  logic [1:0]  sel;

  assign bus_ready   = !half_pend;
  assign status_word = {6'd0, fifo_empty, fifo_full, vint_flag, spr_ovf, spr_hit,
                        odd_field, in_vblank, in_hblank, xfer_busy, pal_std};

  assign act    = half_pend || bus_req;
  assign a_ctrl = half_pend ? half_ctrl : bus_ctrl;
  assign a_wr   = half_pend ? half_wr : bus_wr;
  assign a_word = half_pend ? half_word : (bus_wide ? bus_wdata[31:16] : bus_wdata[15:0]);

  assign inc      = regs[RINC];
  assign len      = {regs[RLENH], regs[RLENL]};
  assign src      = {regs[RSRCH][6:0], regs[RSRCM], regs[RSRCL], 1'b0};
  assign sel      = regs[RSRCH][7:6];
  assign byte_cnt = len * {8'd0, inc};
  assign dma_en   = regs[RMODE][4];

  assign is_reg    = act && a_ctrl && !pend && (a_word[15:13] == 3'b100);
  assign is_first  = act && a_ctrl && !pend && !is_reg;
  assign is_second = act && a_ctrl && pend;
  assign is_data   = act && !a_ctrl;
  assign fill_go   = is_data && a_wr && armed;
  assign addr2     = {a_word[1:0], addr[13:0]};
  assign code2     = {a_word[7:4], code[1:0]};
  assign dma_go    = is_second && dma_en && (code2[5:4] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= 8'd0;
      addr <= '0; code <= '0; pend <= 1'b0; armed <= 1'b0;
      half_pend <= 1'b0; half_ctrl <= 1'b0; half_wr <= 1'b0; half_word <= '0;
      mem_stb <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0; mem_tgt <= '0;
      dma_stb <= 1'b0; dma_op <= '0; dma_src <= '0; dma_dst <= '0; dma_len <= '0;
      dma_inc <= '0; dma_fill <= '0; dma_tgt <= '0;
    end else begin
      mem_stb <= 1'b0;
      dma_stb <= 1'b0;
      if (half_pend) begin
        half_pend <= 1'b0;
      end else if (bus_req && bus_wide) begin
        half_pend <= 1'b1;
        half_ctrl <= bus_ctrl;
        half_wr   <= bus_wr;
        half_word <= bus_wdata[15:0];
      end

      if (is_reg) regs[a_word[RIDX_W+7:8]] <= a_word[7:0];

      if (is_first) begin
        addr <= {2'b00, a_word[13:0]};
        code <= {4'd0, a_word[15:14]};
        pend <= 1'b1;
      end

      if (is_second) begin
        pend <= 1'b0;
        code <= code2;
        addr <= addr2;
        if (dma_go) begin
          dma_src  <= src;
          dma_dst  <= addr2;
          dma_inc  <= inc;
          dma_fill <= '0;
          dma_tgt  <= code2[3:0];
          case (sel)
            2'd2: armed <= 1'b1;
            2'd3: begin
              dma_stb <= 1'b1;
              dma_op  <= OP_COPY;
              dma_len <= len;
            end
            default: begin
              dma_stb <= 1'b1;
              dma_op  <= OP_MEM;
              dma_len <= byte_cnt;
              addr    <= addr2 + byte_cnt;
            end
          endcase
        end
      end

      if (is_data) begin
        if (fill_go) begin
          armed    <= 1'b0;
          dma_stb  <= 1'b1;
          dma_op   <= OP_FILL;
          dma_src  <= src;
          dma_dst  <= addr;
          dma_len  <= len;
          dma_inc  <= inc;
          dma_fill <= a_word;
          dma_tgt  <= code[3:0];
        end else begin
          mem_stb   <= 1'b1;
          mem_we    <= a_wr;
          mem_addr  <= {addr[15:1], 1'b0};
          mem_wdata <= a_word;
          mem_tgt   <= code[3:0];
          addr      <= addr + {8'd0, inc};
        end
      end
    end
  end
endmodule

// File: rtl/dpc_host_port_chk.sv
module dpc_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_ctrl,
  input logic        bus_wr,
  input logic        bus_wide,
  input logic [15:13] hdr,
  input logic        bus_ready,
  input logic        mem_stb,
  input logic        mem_addr0,
  input logic        dma_stb,
  input logic [1:0]  dma_op,
  input logic        pend,
  input logic        armed
);
  a_r5_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |-> !mem_addr0);
  a_r6_lower_half_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wide && bus_ready) |=> !bus_ready);
  a_r6_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);
  a_r3_first_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_req && bus_ctrl && !bus_wide && !pend && hdr != 3'b100) |=> pend);
  a_r4_second_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_req && bus_ctrl && !bus_wide && pend) |=> !pend);
  a_r9_fill_replaces_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_req && !bus_ctrl && bus_wr && !bus_wide && armed)
      |=> (dma_stb && dma_op == 2'd1 && !mem_stb && !armed));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_stb && dma_stb));
endmodule

bind dpc_host_port dpc_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ctrl(bus_ctrl), .bus_wr(bus_wr),
  .bus_wide(bus_wide), .hdr(bus_wdata[15:13]), .bus_ready(bus_ready),
  .mem_stb(mem_stb), .mem_addr0(mem_addr[0]), .dma_stb(dma_stb), .dma_op(dma_op),
  .pend(pend), .armed(armed)
);

// File: tb/dpc_host_port_tb.sv
`timescale 1ns/1ps
module dpc_host_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_ctrl = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [9:0] stv = '0;
  logic bus_ready;
  logic [15:0] status_word;
  logic mem_stb, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [3:0] mem_tgt;
  logic dma_stb;
  logic [1:0] dma_op;
  logic [23:0] dma_src;
  logic [15:0] dma_dst, dma_len, dma_fill;
  logic [7:0] dma_inc;
  logic [3:0] dma_tgt;

  always #5 clk = ~clk;

  dpc_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ctrl(bus_ctrl), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .fifo_empty(stv[9]), .fifo_full(stv[8]), .vint_flag(stv[7]), .spr_ovf(stv[6]),
    .spr_hit(stv[5]), .odd_field(stv[4]), .in_vblank(stv[3]), .in_hblank(stv[2]),
    .xfer_busy(stv[1]), .pal_std(stv[0]), .status_word(status_word),
    .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_tgt(mem_tgt), .dma_stb(dma_stb), .dma_op(dma_op), .dma_src(dma_src),
    .dma_dst(dma_dst), .dma_len(dma_len), .dma_inc(dma_inc), .dma_fill(dma_fill),
    .dma_tgt(dma_tgt)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // reference model state
  int m_reg [32];
  int m_addr, m_code;
  bit m_pend, m_arm;
  int hq [$];
  bit e_ready = 1'b1, e_mem_stb, e_mem_we, e_dma_stb;
  int e_mem_addr, e_mem_wdata, e_mem_tgt;
  int e_op, e_src, e_dst, e_len, e_inc, e_fill, e_tgt;

  task automatic step(input bit c, input bit wr, input int w);
    int inc, len, src, cnt, sel;
    inc = m_reg[15];
    len = m_reg[20] * 256 + m_reg[19];
    src = ((m_reg[23] % 128) * 65536 + m_reg[22] * 256 + m_reg[21]) * 2;
    sel = m_reg[23] / 64;
    if (c) begin
      if (!m_pend && (w / 8192) == 4) begin
        m_reg[(w / 256) % 32] = w % 256;
      end else if (!m_pend) begin
        m_addr = w % 16384;
        m_code = w / 16384;
        m_pend = 1;
      end else begin
        m_pend = 0;
        m_addr = m_addr + (w % 4) * 16384;
        m_code = m_code + ((w / 16) % 16) * 4;
        if (((m_reg[1] / 16) % 2) == 1 && m_code >= 16) begin
          e_src = src; e_dst = m_addr; e_inc = inc; e_fill = 0; e_tgt = m_code % 16;
          if (sel == 2) m_arm = 1;
          else if (sel == 3) begin e_dma_stb = 1; e_op = 2; e_len = len; end
          else begin
            cnt = (len * inc) % 65536;
            e_dma_stb = 1; e_op = 0; e_len = cnt;
            m_addr = (m_addr + cnt) % 65536;
          end
        end
      end
    end else if (wr && m_arm) begin
      m_arm = 0;
      e_dma_stb = 1; e_op = 1; e_src = src; e_dst = m_addr; e_len = len;
      e_inc = inc; e_fill = w; e_tgt = m_code % 16;
    end else begin
      e_mem_stb = 1; e_mem_we = wr; e_mem_addr = m_addr - (m_addr % 2);
      e_mem_wdata = w; e_mem_tgt = m_code % 16;
      m_addr = (m_addr + inc) % 65536;
    end
  endtask

  always @(posedge clk) begin
    e_mem_stb = 0;
    e_dma_stb = 0;
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_addr = 0; m_code = 0; m_pend = 0; m_arm = 0;
      hq.delete();
    end else if (hq.size() != 0) begin
      int c, wr, w;
      c = hq.pop_front(); wr = hq.pop_front(); w = hq.pop_front();
      step(c[0], wr[0], w);
    end else if (bus_req) begin
      if (bus_wide) begin
        hq.push_back(int'(bus_ctrl)); hq.push_back(int'(bus_wr)); hq.push_back(int'(bus_wdata[15:0]));
        step(bus_ctrl, bus_wr, int'(bus_wdata[31:16]));
      end else begin
        step(bus_ctrl, bus_wr, int'(bus_wdata[15:0]));
      end
    end
    e_ready = (hq.size() == 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_ready == e_ready, "bus_ready", bus_ready, e_ready);
      chk(mem_stb == e_mem_stb, "mem_stb", mem_stb, e_mem_stb);
      chk(dma_stb == e_dma_stb, "dma_stb", dma_stb, e_dma_stb);
      if (mem_stb && e_mem_stb) begin
        chk(mem_we == e_mem_we, "mem_we", mem_we, e_mem_we);
        chk(int'(mem_addr) == e_mem_addr, "mem_addr", mem_addr, e_mem_addr);
        chk(int'(mem_wdata) == e_mem_wdata, "mem_wdata", mem_wdata, e_mem_wdata);
        chk(int'(mem_tgt) == e_mem_tgt, "mem_tgt", mem_tgt, e_mem_tgt);
      end
      if (dma_stb && e_dma_stb) begin
        chk(int'(dma_op) == e_op, "dma_op", dma_op, e_op);
        chk(int'(dma_src) == e_src, "dma_src", dma_src, e_src);
        chk(int'(dma_dst) == e_dst, "dma_dst", dma_dst, e_dst);
        chk(int'(dma_len) == e_len, "dma_len", dma_len, e_len);
        chk(int'(dma_inc) == e_inc, "dma_inc", dma_inc, e_inc);
        chk(int'(dma_fill) == e_fill, "dma_fill", dma_fill, e_fill);
        chk(int'(dma_tgt) == e_tgt, "dma_tgt", dma_tgt, e_tgt);
      end
    end
  end

  task automatic acc(input bit c, input bit wr, input bit wide, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_ctrl = c; bus_wr = wr; bus_wide = wide; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    if (wide) @(negedge clk);
  endtask

  task automatic ctl(input logic [15:0] w); acc(1'b1, 1'b1, 1'b0, {16'd0, w}); endtask
  task automatic dwr(input logic [15:0] w); acc(1'b0, 1'b1, 1'b0, {16'd0, w}); endtask
  task automatic drd(); acc(1'b0, 1'b0, 1'b0, 32'd0); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(bus_ready == 1'b1, "reset bus_ready", bus_ready, 1);
    chk(mem_stb == 1'b0, "reset mem_stb", mem_stb, 0);
    chk(dma_stb == 1'b0, "reset dma_stb", dma_stb, 0);
    drd();
    dwr(16'h1111);

    cur_req = "R2";
    ctl(16'h8F02);
    cur_req = "R3";
    ctl(16'h4123);
    dwr(16'hBEEF);
    cur_req = "R5";
    dwr(16'hCAFE);
    drd();

    cur_req = "R4";
    ctl(16'h4000);
    ctl(16'h8F13);
    dwr(16'h0A0A);
    dwr(16'h0B0B);

    cur_req = "R6";
    acc(1'b0, 1'b1, 1'b1, 32'hAAAA_5555);
    acc(1'b1, 1'b1, 1'b1, 32'h4010_0000);
    acc(1'b0, 1'b0, 1'b1, 32'h0);
    acc(1'b1, 1'b1, 1'b1, 32'h8F04_8113);

    cur_req = "R7";
    ctl(16'h9534); ctl(16'h9612); ctl(16'h9705);
    ctl(16'h9308); ctl(16'h9400); ctl(16'h8F02);
    ctl(16'h4100); ctl(16'h0080);
    dwr(16'h0001);
    ctl(16'h8110);
    ctl(16'h4100); ctl(16'h0040);
    dwr(16'h0002);

    cur_req = "R8";
    ctl(16'h4100); ctl(16'h0080);
    dwr(16'h0003);
    ctl(16'h9745);
    ctl(16'h9300); ctl(16'h9480); ctl(16'h8F04);
    ctl(16'h7FFE); ctl(16'h0091);
    dwr(16'h0004);

    cur_req = "R9";
    ctl(16'h9780); ctl(16'h9310); ctl(16'h9400); ctl(16'h8F01);
    ctl(16'h4200); ctl(16'h0080);
    drd();
    dwr(16'h1234);
    dwr(16'h5678);

    cur_req = "R10";
    ctl(16'h97C0);
    ctl(16'h0300); ctl(16'h00C3);
    dwr(16'h9ABC);

    cur_req = "R11";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      stv = 10'd1 << i;
      #1;
      chk(status_word == {6'd0, stv}, "status_word", status_word, {6'd0, stv});
    end
    @(negedge clk); stv = 10'h3FF; #1;
    chk(status_word == 16'h03FF, "status_word all", status_word, 16'h03FF);
    @(negedge clk); stv = 10'h000; #1;
    chk(status_word == 16'h0000, "status_word none", status_word, 16'h0000);

    cur_req = "R5";
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      acc(lfsr[0], lfsr[1] | lfsr[2], lfsr[3] & lfsr[4], {lfsr ^ 16'h5A5A, lfsr});
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule